// File: doc/BRIEF.md
# Two-Byte Serial Register Port

This block is a slave port through which a host controller reaches a small set of configuration registers over a four-wire serial link: an active-low select, a serial clock, serial data in and serial data out. An open-drain-style active-low request line is also provided. Each access is one frame of sixteen serial clock pulses. A frame moves an address byte and then a data byte toward the block. At the same time it returns one queued sixteen-bit message to the host. Input bits and output bits use opposite edges of each pulse. The host chooses which edge does which through a phase setting held in a register. The port works with either idle level of the serial clock, because it counts transitions from the level seen when the select falls.

The block samples all serial pins with its own system clock, which must run well above the serial clock. A transfer FSM has three states. IDLE waits for the select to fall. XFER counts 32 serial edges. HOLD waits for the select to rise after a complete frame. The FSM takes IDLE->XFER when the select falls. It takes XFER->HOLD on the 32nd edge, and decodes the frame at that moment. It takes XFER->IDLE when the select rises early, and the frame is then discarded. It takes HOLD->IDLE when the select rises. Messages for the host come from two sources: read-back answers and spontaneous event reports from the surrounding logic. They wait in a four-entry queue. The request line goes low while the queue holds anything and the select is high.

Top module: `scp_port`

## Requirements
- R1: A frame takes effect only when 32 serial clock transitions occur while select is low. If select rises earlier, no register changes and nothing is queued. The message popped when that frame started is lost.
- R2: After reset the phase setting is A. In phase A, odd transitions (1st, 3rd, ...) counted from the select fall capture data in. Even transitions advance data out. The first output bit is presented as soon as select falls.
- R3: Writing data bit 0 = 1 to address 0x20 (first byte 0x40) selects phase B. Phase B swaps the roles: odd transitions advance data out, and even transitions capture data in. A read-back of address 0x20 returns the phase bit in data bit 0. A new phase applies from the next frame.
- R4: Frames work the same whether the serial clock idles low or high.
- R5: In the first byte, bits 7..1 are the address and bit 0 = 0 means write. When the address is below 8, the second byte is stored in that register. A write to any other address (apart from 0x20 and the wide region) changes nothing.
- R6: First-byte bit 0 = 1 is a read-back request, and the second byte is ignored. The message {address, 1, register value} is queued. An unmapped address returns data 0x00.
- R7: When the first byte's upper nibble is 0xF, the frame writes the 12-bit register `wide_o`. First-byte bits 3..0 become bits 11..8 and the second byte becomes bits 7..0.
- R8: A one-cycle `evt_i` pulse queues the message {evt_addr_i, 0, evt_data_i}.
- R9: When select falls, the oldest queued message is removed and shifted out MSB first during the frame. With an empty queue the frame returns sixteen zeros.
- R10: `irq_n_o` is low exactly when the queue is non-empty and select was high in the previous cycle. It goes high in the cycle after select falls and never falls while select is low.
- R11: `sdo_oe_o` is 1 only while select is low.
- R12: The queue holds up to four messages in arrival order. A message that arrives while the queue is full replaces the newest entry.
- R13: After reset `irq_n_o` = 1, `wide_o` = 0, all registers read 0, and the phase is A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n_i | input | 1 | Port select, active low |
| sclk_i | input | 1 | Serial clock, either idle level |
| sdi_i | input | 1 | Serial data toward the block |
| sdo_o | output | 1 | Serial data toward the host |
| sdo_oe_o | output | 1 | Drive enable for sdo_o |
| irq_n_o | output | 1 | Read request, active low |
| evt_i | input | 1 | Spontaneous report strobe |
| evt_addr_i | input | 7 | Address field of the report |
| evt_data_i | input | 8 | Data field of the report |
| wide_o | output | 12 | Contents of the 12-bit register |

## Verification
Assertions check on every cycle that:
- the edge count never passes 32;
- a decoded frame always coincides with entry to HOLD;
- the queue level stays within four, and an overflowing report keeps it full;
- the request line releases after select is low and never falls while select is low.

The bench covers the rest through scenarios:
- phase A and phase B, with the data line toggling between capture edges;
- both clock idle levels and aborted frames;
- the wide register, read-back contents, and queue order with overwrite.

Each returned message is compared with a bench model of the registers and queue.

// File: rtl/scp_pkg.sv
package scp_pkg;
    localparam int MSG_W = 16;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_XFER = 2'd1,
        ST_HOLD = 2'd2
    } xfer_state_t;
endpackage

// File: rtl/scp_shifter.sv
module scp_shifter
    import scp_pkg::*;
#(
    parameter int FRAME_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cs_n_i,
    input  logic               sclk_i,
    input  logic               sdi_i,
    input  logic               mode_b_i,
    input  logic [FRAME_W-1:0] head_i,
    output logic               start_o,
    output logic               frame_v_o,
    output logic [FRAME_W-1:0] frame_o,
    output logic               sdo_o
);
    localparam int EDGES = 2 * FRAME_W;
    localparam int CW    = $clog2(EDGES + 1);

    xfer_state_t st, st_nx;
    logic s_cs, p_cs, s_sclk, p_sclk, s_sdi;
    logic [CW-1:0] edge_cnt, cnt_nx;
    logic [FRAME_W-1:0] in_sr, in_nx, out_sr;
    logic mode_q, sdo_q;
    logic cs_fall, sedge, in_edge, out_edge, last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_cs <= 1'b1; p_cs <= 1'b1;
            s_sclk <= 1'b0; p_sclk <= 1'b0; s_sdi <= 1'b0;
        end else begin
            s_cs <= cs_n_i; p_cs <= s_cs;
            s_sclk <= sclk_i; p_sclk <= s_sclk; s_sdi <= sdi_i;
        end
    end

    assign cs_fall  = p_cs & ~s_cs;
    assign sedge    = ~s_cs & ~p_cs & (s_sclk ^ p_sclk);
    assign cnt_nx   = edge_cnt + 1'b1;
    assign in_edge  = sedge & (cnt_nx[0] ^ mode_q);
    assign out_edge = sedge & ~(cnt_nx[0] ^ mode_q);
    assign in_nx    = in_edge ? {in_sr[FRAME_W-2:0], s_sdi} : in_sr;
    assign last     = sedge && (cnt_nx == CW'(EDGES));
    assign start_o  = (st == ST_IDLE) && cs_fall;
    assign sdo_o    = sdo_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE: if (cs_fall) st_nx = ST_XFER;
            ST_XFER: begin
                if (s_cs)      st_nx = ST_IDLE;
                else if (last) st_nx = ST_HOLD;
            end
            ST_HOLD: if (s_cs) st_nx = ST_IDLE;
            default: st_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            edge_cnt <= '0; in_sr <= '0; out_sr <= '0;
            mode_q <= 1'b0; sdo_q <= 1'b0;
            frame_v_o <= 1'b0; frame_o <= '0;
        end else begin
            frame_v_o <= 1'b0;
            if (start_o) begin
                edge_cnt <= '0;
                in_sr    <= '0;
                mode_q   <= mode_b_i;
                if (mode_b_i) begin
                    sdo_q  <= 1'b0;
                    out_sr <= head_i;
                end else begin
                    sdo_q  <= head_i[FRAME_W-1];
                    out_sr <= {head_i[FRAME_W-2:0], 1'b0};
                end
            end else if (st == ST_XFER && sedge) begin
                edge_cnt <= cnt_nx;
                in_sr    <= in_nx;
                if (out_edge) begin
                    sdo_q  <= out_sr[FRAME_W-1];
                    out_sr <= {out_sr[FRAME_W-2:0], 1'b0};
                end
                if (last) begin
                    frame_v_o <= 1'b1;
                    frame_o   <= in_nx;
                end
            end
        end
    end

    // R1: edge count never runs past one full frame
    a_r1_count_limit: assert property (@(posedge clk) disable iff (!rst_n)
        edge_cnt <= CW'(EDGES));
    // R1: a frame is only delivered on the way into HOLD
    a_r1_frame_in_hold: assert property (@(posedge clk) disable iff (!rst_n)
        frame_v_o |-> (st == ST_HOLD));
endmodule

// File: rtl/scp_regs.sv
module scp_regs #(
    parameter int         NREG      = 8,
    parameter logic [6:0] MODE_ADDR = 7'h20,
    parameter logic [3:0] WIDE_TAG  = 4'hF
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        frame_v_i,
    input  logic [15:0] frame_i,
    input  logic        rb_take_i,
    output logic        mode_b_o,
    output logic [11:0] wide_o,
    output logic        rb_req_o,
    output logic [15:0] rb_msg_o
);
    localparam int IW = $clog2(NREG);

    logic [7:0] regs [NREG];
    logic [6:0] addr;
    logic       rd_flag, mapped, is_wide, is_mode;
    logic [7:0] data, rdata;

    assign addr    = frame_i[15:9];
    assign rd_flag = frame_i[8];
    assign data    = frame_i[7:0];
    assign is_wide = frame_i[15:12] == WIDE_TAG;
    assign is_mode = addr == MODE_ADDR;
    assign mapped  = int'(addr) < NREG;

    always_comb begin
        if (is_mode)     rdata = {7'd0, mode_b_o};
        else if (mapped) rdata = regs[addr[IW-1:0]];
        else             rdata = 8'd0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs[i] <= 8'd0;
            mode_b_o <= 1'b0;
            wide_o   <= 12'd0;
            rb_req_o <= 1'b0;
            rb_msg_o <= 16'd0;
        end else if (frame_v_i) begin
            if (is_wide) begin
                wide_o <= {frame_i[11:8], data};
            end else if (rd_flag) begin
                rb_req_o <= 1'b1;
                rb_msg_o <= {addr, 1'b1, rdata};
            end else if (is_mode) begin
                mode_b_o <= data[0];
            end else if (mapped) begin
                regs[addr[IW-1:0]] <= data;
            end
        end else if (rb_take_i) begin
            rb_req_o <= 1'b0;
        end
    end
endmodule

// File: rtl/scp_msgq.sv
module scp_msgq #(
    parameter int DEPTH = 4,
    parameter int W     = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push_i,
    input  logic [W-1:0] data_i,
    input  logic         pop_i,
    output logic [W-1:0] head_o,
    output logic         nonempty_o
);
    localparam int PW = $clog2(DEPTH);
    localparam int LW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wp, rp;
    logic [LW-1:0] level;
    logic full, do_pop, push_new;

    assign full       = level == LW'(DEPTH);
    assign do_pop     = pop_i && (level != '0);
    assign push_new   = push_i && (!full || do_pop);
    assign head_o     = mem[rp];
    assign nonempty_o = level != '0;

    always_ff @(posedge clk) begin
        if (push_new)    mem[wp] <= data_i;
        else if (push_i) mem[wp - 1'b1] <= data_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp <= '0; rp <= '0; level <= '0;
        end else begin
            if (push_new) wp <= wp + 1'b1;
            if (do_pop)   rp <= rp + 1'b1;
            if (push_new && !do_pop)      level <= level + 1'b1;
            else if (!push_new && do_pop) level <= level - 1'b1;
        end
    end

    // R12: queue level bounded by its depth
    a_r12_level_max: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LW'(DEPTH));
    // R12: overflowing push replaces an entry and leaves the queue full
    a_r12_full_replace: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && full && !pop_i) |=> (level == LW'(DEPTH)));
endmodule

// File: rtl/scp_port.sv
module scp_port
    import scp_pkg::*;
#(
    parameter int QDEPTH = 4,
    parameter int NREG   = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cs_n_i,
    input  logic        sclk_i,
    input  logic        sdi_i,
    output logic        sdo_o,
    output logic        sdo_oe_o,
    output logic        irq_n_o,
    input  logic        evt_i,
    input  logic [6:0]  evt_addr_i,
    input  logic [7:0]  evt_data_i,
    output logic [11:0] wide_o
);
    logic             start, frame_v, mode_b, rb_req, nonempty, pop, push, rb_take;
    logic [MSG_W-1:0] frame, rb_msg, head, head_sel, push_data;

    assign rb_take   = rb_req & ~evt_i;
    assign push      = evt_i | rb_req;
    assign push_data = evt_i ? {evt_addr_i, 1'b0, evt_data_i} : rb_msg;
    assign pop       = start & nonempty;
    assign head_sel  = nonempty ? head : '0;
    assign sdo_oe_o  = ~cs_n_i;

    scp_shifter #(.FRAME_W(MSG_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n_i), .sclk_i(sclk_i),
        .sdi_i(sdi_i), .mode_b_i(mode_b), .head_i(head_sel),
        .start_o(start), .frame_v_o(frame_v), .frame_o(frame), .sdo_o(sdo_o)
    );

    scp_regs #(.NREG(NREG)) u_regs (
        .clk(clk), .rst_n(rst_n), .frame_v_i(frame_v), .frame_i(frame),
        .rb_take_i(rb_take), .mode_b_o(mode_b), .wide_o(wide_o),
        .rb_req_o(rb_req), .rb_msg_o(rb_msg)
    );

    scp_msgq #(.DEPTH(QDEPTH), .W(MSG_W)) u_q (
        .clk(clk), .rst_n(rst_n), .push_i(push), .data_i(push_data),
        .pop_i(pop), .head_o(head), .nonempty_o(nonempty)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      irq_n_o <= 1'b1;
        else if (cs_n_i) irq_n_o <= ~nonempty;
        else             irq_n_o <= 1'b1;
    end

    // R10: request released once select is low
    a_r10_release: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n_i |=> irq_n_o);
    // R10: request never falls while select is low
    a_r10_no_fall_low: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_n_o) |-> $past(cs_n_i));
endmodule

// File: tb/scp_port_tb.sv
module scp_port_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0, evt = 1'b0;
    logic [6:0] evt_addr = '0;
    logic [7:0] evt_data = '0;
    logic sdo, sdo_oe, irq_n;
    logic [11:0] wide;

    int checks = 0;
    int errors = 0;
    logic [15:0] mq [4];
    int qn = 0;
    logic [7:0] mreg [8];
    logic mode_b = 1'b0;

    always #4 clk = ~clk;

    scp_port u_dut (
        .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .sclk_i(sclk), .sdi_i(sdi),
        .sdo_o(sdo), .sdo_oe_o(sdo_oe), .irq_n_o(irq_n), .evt_i(evt),
        .evt_addr_i(evt_addr), .evt_data_i(evt_data), .wide_o(wide)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic mpush(input logic [15:0] m);
        if (qn < 4) begin mq[qn] = m; qn++; end
        else mq[3] = m;
    endtask

    task automatic mpop(output logic [15:0] m);
        if (qn == 0) m = 16'h0000;
        else begin
            m = mq[0];
            for (int i = 0; i < 3; i++) mq[i] = mq[i+1];
            qn--;
        end
    endtask

    task automatic xfer(input logic [15:0] tx, input bit mb, input bit pol,
                        input int n_edges, output logic [15:0] rx);
        rx = '0;
        sclk = pol;
        @(negedge clk) cs_n = 1'b0;
        repeat (4) @(negedge clk);
        chk("R11 drive enable while selected", sdo_oe, 1'b1);
        chk("R10 request released while selected", irq_n, 1'b1);
        for (int e = 1; e <= n_edges; e++) begin
            bit odd = (e % 2) == 1;
            int bi = (e - 1) / 2;
            bit capt = odd ^ mb;
            sdi = capt ? tx[15-bi] : ~tx[15-bi];
            if (!odd) rx = {rx[14:0], sdo};
            repeat (2) @(negedge clk);
            sclk = ~sclk;
            repeat (3) @(negedge clk);
        end
        @(negedge clk) cs_n = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    task automatic event_in(input logic [6:0] a, input logic [7:0] d);
        @(negedge clk);
        evt = 1'b1; evt_addr = a; evt_data = d;
        @(negedge clk);
        evt = 1'b0;
        repeat (2) @(negedge clk);
        mpush({a, 1'b0, d});
    endtask

    // full frame with model bookkeeping, rx checked against model pop
    task automatic frame(input string req, input logic [15:0] tx, input bit pol);
        logic [15:0] exp, rx;
        mpop(exp);
        xfer(tx, mode_b, pol, 32, rx);
        chk(req, rx, exp);
        if (tx[15:12] != 4'hF) begin
            if (tx[8]) begin
                logic [7:0] v;
                if (tx[15:9] == 7'h20) v = {7'd0, mode_b};
                else if (tx[15:9] < 7'd8) v = mreg[tx[11:9]];
                else v = 8'h00;
                mpush({tx[15:9], 1'b1, v});
            end else if (tx[15:9] == 7'h20) mode_b = tx[0];
            else if (tx[15:9] < 7'd8) mreg[tx[11:9]] = tx[7:0];
        end
        chk("R10 request level after frame", irq_n, (qn == 0));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] rx, exp;
        void'($urandom(32'd4242));
        for (int i = 0; i < 8; i++) mreg[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R13 reset state, R11 idle drive enable
        chk("R13 request idle after reset", irq_n, 1'b1);
        chk("R13 wide register cleared", wide, 12'h000);
        chk("R11 no drive when deselected", sdo_oe, 1'b0);

        // R2 default phase A, R5 write, R9 empty queue gives zeros
        frame("R9 empty queue sends zeros", {7'd3, 1'b0, 8'hA5}, 1'b0);
        // R6 read-back with garbage second byte
        frame("R9 empty before read-back", {7'd3, 1'b1, 8'hFF}, 1'b0);
        chk("R10 request low with pending message", irq_n, 1'b0);
        frame("R6 read-back returns stored value", {7'h18, 1'b0, 8'h11}, 1'b0);
        // R13 registers start at zero
        frame("R13 zero before read-back", {7'd6, 1'b1, 8'h00}, 1'b0);
        frame("R13 register read zero after reset", {7'h18, 1'b0, 8'h00}, 1'b0);
        // R5 unmapped write has no effect; R6 unmapped read gives zero data
        frame("R5 unmapped read queued", {7'h18, 1'b1, 8'h00}, 1'b0);
        frame("R6 unmapped read-back data zero", {7'd3, 1'b1, 8'h00}, 1'b0);
        frame("R5 register unchanged by unmapped write", {7'h19, 1'b0, 8'h00}, 1'b0);

        // R8 + R12 five reports into four slots, newest replaced
        event_in(7'h11, 8'h01);
        event_in(7'h12, 8'h02);
        event_in(7'h13, 8'h03);
        event_in(7'h14, 8'h04);
        event_in(7'h15, 8'h05);
        chk("R12 model depth", qn, 4);
        for (int i = 0; i < 5; i++)
            frame("R12 queue order with overwrite", {7'h19, 1'b0, 8'h00}, 1'b0);

        // R7 wide register
        frame("R7 wide write reply", {4'hF, 4'h9, 8'h3C}, 1'b0);
        chk("R7 wide register value", wide, 12'h93C);
        frame("R7 wide write with other data", {4'hF, 4'h2, 8'hD1}, 1'b1);
        chk("R7 wide register second value", wide, 12'h2D1);

        // R4 clock idles high
        frame("R4 write with high idle clock", {7'd1, 1'b0, 8'h5A}, 1'b1);
        frame("R4 read-back request high idle", {7'd1, 1'b1, 8'h00}, 1'b1);
        frame("R4 read-back value high idle", {7'h19, 1'b0, 8'h00}, 1'b1);

        // R1 aborted frame: no write, nothing queued
        xfer({7'd2, 1'b0, 8'h55}, mode_b, 1'b0, 20, rx);
        chk("R1 aborted frame leaves request idle", irq_n, 1'b1);
        frame("R1 read-back after abort", {7'd2, 1'b1, 8'h00}, 1'b0);
        frame("R1 aborted write did not land", {7'h19, 1'b0, 8'h00}, 1'b0);
        xfer({7'd2, 1'b1, 8'h00}, mode_b, 1'b0, 31, rx);
        chk("R1 31-edge read-back not queued", irq_n, 1'b1);

        // R3 switch to phase B, data line toggles between capture edges
        frame("R3 phase select write", {7'h20, 1'b0, 8'h01}, 1'b0);
        frame("R3 write in phase B", {7'd4, 1'b0, 8'h3E}, 1'b0);
        frame("R3 read-back in phase B", {7'd4, 1'b1, 8'h00}, 1'b1);
        frame("R3 phase B reply", {7'h20, 1'b1, 8'h00}, 1'b0);
        frame("R3 phase bit read-back", {7'h20, 1'b0, 8'h00}, 1'b0);
        chk("R3 phase returned to A in model", mode_b, 1'b0);
        frame("R2 phase A restored", {7'd4, 1'b1, 8'h00}, 1'b0);
        frame("R2 phase A read-back", {7'h19, 1'b0, 8'h00}, 1'b0);

        // random mix
        for (int i = 0; i < 50; i++) begin
            int unsigned op = $urandom_range(0, 3);
            logic [2:0] a = 3'($urandom_range(0, 7));
            logic [7:0] d = 8'($urandom);
            bit pol = 1'($urandom_range(0, 1));
            case (op)
                0: frame("R5 random write", {4'd0, a, 1'b0, d}, pol);
                1: frame("R6 random read-back", {4'd0, a, 1'b1, d}, pol);
                2: event_in(7'($urandom), d);
                default: frame("R9 random drain", {7'h19, 1'b0, 8'h00}, pol);
            endcase
        end
        while (qn > 0) frame("R12 final drain", {7'h19, 1'b0, 8'h00}, 1'b0);
        chk("R10 request idle at end", irq_n, 1'b1);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule